// File: doc/BRIEF.md
# Buck Controller Power-Up Sequencer

This block orders the start-up and shut-down of each output channel of a multi-channel switching regulator controller. Every input is an already-compared, synchronous logic flag. Each channel has its own enable, protection shutdown request and end-of-soft-start flag. All channels share a controller supply-good flag and a power-stage-driver-ready flag. A channel waits until all of its start conditions hold, in whatever order they arrive. It then steps through a fixed reset interval, a delay chosen by a 3-bit code, a soft-start phase and a power-good delay before it reports power good.

The outputs of each channel are a PWM enable, a PWM high-impedance request, a soft-start-active flag and power good. If a start condition is lost, the channel at once floats its PWM output and drops power good. It then restarts from the beginning. A shutdown request from the protection logic parks the channel until the request clears. A memory-rail mode makes the second channel use the delay code of the first. Every duration is counted in clock ticks.

Top module: `pwr_seq_top`

## Requirements
- R1: A channel leaves idle only when its enable, the shared supply-good flag and the shared driver-ready flag are all high and its shutdown request is low, whichever of these arrives last. While any of them is missing, it stays idle with its PWM output floated.
- R2: The fixed reset interval lasts RST_TICKS cycles. With a delay of zero, the channel enters soft start on the RST_TICKS-th clock edge after the edge that first samples all start conditions true.
- R3: Delay codes 0 to 7 select 0, 1, 2, 3, 4, 8, 12 and 20 units, and one unit is UNIT_TICKS cycles. The delay follows the reset interval, so soft start begins RST_TICKS plus the delay in cycles after the start edge. Code 0 goes straight from the reset interval to soft start.
- R4: The delay code is captured at the end of the reset interval. A change to the code while the delay is running has no effect on its length.
- R5: pwm_tri is high in idle, reset interval, delay and shutdown, and pwm_en is low there. From soft start onward pwm_tri is low and pwm_en is high. ss_active is high only during soft start, which lasts until ss_done is sampled high.
- R6: pgood rises on the PG_TICKS-th edge after the edge that samples ss_done high during soft start.
- R7: When enable is sampled low, the channel is idle after that same edge: pgood is low, pwm_en is low and pwm_tri is high.
- R8: When supply-good or driver-ready is sampled low, every active channel is idle after that edge. When the flags return, the channel runs the full reset, delay and soft-start sequence again.
- R9: A shutdown request in any active state moves the channel to shutdown (PWM floated, pgood low) on the next edge. It stays there while the request is high. When the request clears, it returns to idle and restarts the full sequence.
- R10: With ddr_mode high, channel 1 uses the delay code of channel 0. With ddr_mode low, each channel uses its own code.
- R11: While reset is asserted, and right after it, every channel is idle with PWM floated and pgood low. state_dbg carries 3 bits per channel, with channel c at bits [3c+2:3c]. Its codes are idle 0, reset interval 1, delay 2, soft start 3, power-good delay 4, run 5 and shutdown 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ddr_mode | input | 1 | Channel 1 takes channel 0's delay code |
| supply_ok | input | 1 | Controller supply above its good threshold (shared) |
| drv_ready | input | 1 | Power stage drivers ready (shared) |
| en | input | NUM_CH | Per-channel enable |
| shut_req | input | NUM_CH | Per-channel shutdown request from protection logic |
| ss_done | input | NUM_CH | Per-channel end of soft-start ramp |
| dly_code | input | 3*NUM_CH | Per-channel delay code, channel c at [3c+2:3c] |
| pwm_en | output | NUM_CH | PWM modulation allowed |
| pwm_tri | output | NUM_CH | PWM output held high-impedance |
| ss_active | output | NUM_CH | Soft start in progress |
| pgood | output | NUM_CH | Power good |
| state_dbg | output | 3*NUM_CH | Sequencer state per channel |

## Verification
The bench runs all eight delay codes on both channels, with memory-rail mode on and off, and measures the cycle of soft-start entry and of power good against arithmetic built from the tick parameters. A design that is off by one in the reset or delay counter, or that decodes the code table wrongly, shows up as a wrong cycle count. It also brings each start condition up last in turn. A design that starts on the first condition rather than on all of them leaves idle too early. A code change in the middle of the delay must not move soft start, so a design that decodes the code live fails that run. Enable loss, driver-ready or supply loss in run, and a held shutdown request each have to float the output within one cycle and then give a full-length restart. A design that resumed mid-sequence would reach soft start too soon.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RST_WAIT = 3'd1,
    ST_DELAY    = 3'd2,
    ST_SOFT     = 3'd3,
    ST_PG_WAIT  = 3'd4,
    ST_RUN      = 3'd5,
    ST_SHUT     = 3'd6
  } seq_state_t;

  // Delay length in units for each 3-bit code.
  function automatic int unsigned dly_units(input logic [2:0] code);
    case (code)
      3'd0:    dly_units = 0;
      3'd1:    dly_units = 1;
      3'd2:    dly_units = 2;
      3'd3:    dly_units = 3;
      3'd4:    dly_units = 4;
      3'd5:    dly_units = 8;
      3'd6:    dly_units = 12;
      default: dly_units = 20;
    endcase
  endfunction

endpackage

// File: rtl/pwr_seq_rst_sync.sv
module pwr_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sr[STAGES-1];
endmodule

// File: rtl/pwr_seq_chan.sv
module pwr_seq_chan
  import pwr_seq_pkg::*;
#(
  parameter int RST_TICKS  = 200,
  parameter int UNIT_TICKS = 100,
  parameter int PG_TICKS   = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       supply_ok,
  input  logic       drv_ready,
  input  logic       shut_req,
  input  logic       ss_done,
  input  logic [2:0] dly_code,
  output logic       pwm_en,
  output logic       pwm_tri,
  output logic       ss_active,
  output logic       pgood,
  output logic [2:0] state_o
);
  localparam int MAX_DLY = 20 * UNIT_TICKS;
  localparam int MAX_A   = (RST_TICKS > MAX_DLY) ? RST_TICKS : MAX_DLY;
  localparam int MAX_T   = (MAX_A > PG_TICKS) ? MAX_A : PG_TICKS;
  localparam int CW      = $clog2(MAX_T + 1);

  seq_state_t    st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [CW-1:0] tgt;
  logic [CW-1:0] dly_ticks;
  logic          tgt_ld;
  logic          ready;

  assign ready     = en & supply_ok & drv_ready;
  assign dly_ticks = CW'(dly_units(dly_code) * UNIT_TICKS);

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    tgt_ld = 1'b0;
    if (st == ST_IDLE) begin
      if (ready && !shut_req) begin
        st_n  = ST_RST_WAIT;
        cnt_n = '0;
      end
    end else if (!ready) begin
      st_n = ST_IDLE;
    end else if (shut_req && st != ST_SHUT) begin
      st_n = ST_SHUT;
    end else begin
      case (st)
        ST_RST_WAIT: begin
          if (cnt == CW'(RST_TICKS - 1)) begin
            tgt_ld = 1'b1;
            cnt_n  = '0;
            st_n   = (dly_ticks == '0) ? ST_SOFT : ST_DELAY;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        ST_DELAY: begin
          if (cnt == tgt - 1'b1) begin
            cnt_n = '0;
            st_n  = ST_SOFT;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        ST_SOFT: begin
          if (ss_done) begin
            cnt_n = '0;
            st_n  = ST_PG_WAIT;
          end
        end
        ST_PG_WAIT: begin
          if (cnt == CW'(PG_TICKS - 1)) begin
            cnt_n = '0;
            st_n  = ST_RUN;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        ST_SHUT: begin
          if (!shut_req) st_n = ST_IDLE;
        end
        default: st_n = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tgt <= '0;
    else if (tgt_ld) tgt <= dly_ticks;
  end

  assign ss_active = (st == ST_SOFT);
  assign pgood     = (st == ST_RUN);
  assign pwm_en    = (st == ST_SOFT) || (st == ST_PG_WAIT) || (st == ST_RUN);
  assign pwm_tri   = !pwm_en;
  assign state_o   = st;

  // R1: no departure from idle without all start conditions
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !(ready && !shut_req)) |=> (st == ST_IDLE));

  // R4: captured delay target is frozen while the delay runs
  a_r4_tgt_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DELAY) |=> (st != ST_DELAY || $stable(tgt)));

  // R5: soft start is reached only from the reset interval or the delay
  a_r5_ss_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_active) |-> ($past(st) == ST_RST_WAIT || $past(st) == ST_DELAY));

  // R6: power good only follows the power-good delay
  a_r6_pg_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood) |-> ($past(st) == ST_PG_WAIT));

  // R7: enable loss floats the output on the next cycle
  a_r7_en_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pgood && pwm_tri));

  // R8: supply or driver loss floats the output on the next cycle
  a_r8_rail_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !(supply_ok && drv_ready) |=> (st == ST_IDLE));

  // R9: shutdown is held while the request stays high
  a_r9_shut_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SHUT && shut_req && ready) |=> (st == ST_SHUT));

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int RST_TICKS  = 200,
  parameter int UNIT_TICKS = 100,
  parameter int PG_TICKS   = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ddr_mode,
  input  logic                  supply_ok,
  input  logic                  drv_ready,
  input  logic [NUM_CH-1:0]     en,
  input  logic [NUM_CH-1:0]     shut_req,
  input  logic [NUM_CH-1:0]     ss_done,
  input  logic [3*NUM_CH-1:0]   dly_code,
  output logic [NUM_CH-1:0]     pwm_en,
  output logic [NUM_CH-1:0]     pwm_tri,
  output logic [NUM_CH-1:0]     ss_active,
  output logic [NUM_CH-1:0]     pgood,
  output logic [3*NUM_CH-1:0]   state_dbg
);
  logic rst_sync_n;

  pwr_seq_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [2:0] code_sel;
    if (c == 1) begin : g_pair
      assign code_sel = ddr_mode ? dly_code[2:0] : dly_code[5:3];
    end else begin : g_own
      assign code_sel = dly_code[3*c +: 3];
    end

    pwr_seq_chan #(
      .RST_TICKS (RST_TICKS),
      .UNIT_TICKS(UNIT_TICKS),
      .PG_TICKS  (PG_TICKS)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .en       (en[c]),
      .supply_ok(supply_ok),
      .drv_ready(drv_ready),
      .shut_req (shut_req[c]),
      .ss_done  (ss_done[c]),
      .dly_code (code_sel),
      .pwm_en   (pwm_en[c]),
      .pwm_tri  (pwm_tri[c]),
      .ss_active(ss_active[c]),
      .pgood    (pgood[c]),
      .state_o  (state_dbg[3*c +: 3])
    );
  end

  // R11: floated and not good while held in reset
  always_comb begin
    if (!rst_sync_n) a_r11_reset_state: assert (pgood == '0 && pwm_en == '0);
  end

endmodule

// File: tb/pwr_seq_top_tb.sv
module pwr_seq_top_tb;
  localparam int NCH = 2;
  localparam int RT  = 6;
  localparam int UT  = 3;
  localparam int PT  = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             ddr_mode, supply_ok, drv_ready;
  logic [NCH-1:0]   en, shut_req, ss_done;
  logic [3*NCH-1:0] dly_code;
  logic [NCH-1:0]   pwm_en, pwm_tri, ss_active, pgood;
  logic [3*NCH-1:0] state_dbg;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  pwr_seq_top #(.NUM_CH(NCH), .RST_TICKS(RT), .UNIT_TICKS(UT), .PG_TICKS(PT)) u_dut (
    .clk(clk), .rst_n(rst_n), .ddr_mode(ddr_mode), .supply_ok(supply_ok),
    .drv_ready(drv_ready), .en(en), .shut_req(shut_req), .ss_done(ss_done),
    .dly_code(dly_code), .pwm_en(pwm_en), .pwm_tri(pwm_tri),
    .ss_active(ss_active), .pgood(pgood), .state_dbg(state_dbg)
  );

  function automatic int units_of(input int code);
    int tbl[8] = '{0, 1, 2, 3, 4, 8, 12, 20};
    return tbl[code];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int st_of(input int ch);
    return int'(state_dbg[3*ch +: 3]);
  endfunction

  // Counts negedges until soft start shows; returns count.
  task automatic wait_ss(input int ch, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n < 2 && ss_active[ch] == 1'b0)
        chk(pwm_tri[ch] && !pwm_en[ch], "R5 tri before soft start", pwm_tri[ch], 1);
    end while (!ss_active[ch] && n < 300);
  endtask

  task automatic wait_pg(input int ch, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pgood[ch] && n < 300);
  endtask

  // From a negedge at which the channel will start on the next edge.
  task automatic run_to_good(input int ch, input int exp_units, input string tag);
    int n;
    wait_ss(ch, n);
    chk(n == RT + exp_units * UT + 1, tag, n, RT + exp_units * UT + 1);
    chk(pwm_en[ch] && !pwm_tri[ch], "R5 pwm enabled in soft start", pwm_en[ch], 1);
    ss_done[ch] = 1'b1;
    wait_pg(ch, n);
    chk(n == PT + 1, "R6 power good delay", n, PT + 1);
    chk(st_of(ch) == 5, "R11 run code", st_of(ch), 5);
    ss_done[ch] = 1'b0;
  endtask

  task automatic drop_en(input int ch);
    en[ch] = 1'b0;
    @(negedge clk);
    chk(!pgood[ch] && pwm_tri[ch], "R7 enable loss", pgood[ch], 0);
    chk(st_of(ch) == 0, "R7 idle after enable loss", st_of(ch), 0);
  endtask

  initial begin
    int n;
    rst_n = 1'b0; ddr_mode = 1'b0; supply_ok = 1'b1; drv_ready = 1'b1;
    en = '0; shut_req = '0; ss_done = '0; dly_code = '0;
    repeat (3) @(negedge clk);
    chk(pgood == '0 && pwm_tri == '1, "R11 reset outputs", pgood, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(state_dbg == '0 && pwm_en == '0, "R11 idle after reset", state_dbg, 0);

    // R3 / R10 sweep over codes, channels and memory-rail mode
    for (int d = 0; d < 2; d++) begin
      for (int ch = 0; ch < NCH; ch++) begin
        for (int c = 0; c < 8; c++) begin
          int other, expu;
          other = 7 - c;
          ddr_mode = d[0];
          dly_code[3*ch +: 3]     = 3'(c);
          dly_code[3*(1-ch) +: 3] = 3'(other);
          expu = (ch == 1 && d == 1) ? units_of(other) : units_of(c);
          en[ch] = 1'b1;
          run_to_good(ch, expu, (ch == 1 && d == 1) ? "R10 shared code" : "R3 delay code");
          drop_en(ch);
        end
      end
    end
    ddr_mode = 1'b0;
    dly_code = {3'd0, 3'd1};

    // R2 zero delay on channel 1
    en[1] = 1'b1;
    run_to_good(1, 0, "R2 reset interval");
    drop_en(1);

    // R1 arrival order: each condition last
    for (int w = 0; w < 3; w++) begin
      supply_ok = (w != 1); drv_ready = (w != 2); en[0] = (w != 0);
      repeat (5) @(negedge clk);
      chk(st_of(0) == 0 && pwm_tri[0], "R1 waits for last condition", st_of(0), 0);
      supply_ok = 1'b1; drv_ready = 1'b1; en[0] = 1'b1;
      run_to_good(0, 1, "R1 start on last condition");
      drop_en(0);
    end

    // R1 shutdown request blocks start
    shut_req[0] = 1'b1; en[0] = 1'b1;
    repeat (4) @(negedge clk);
    chk(st_of(0) == 0, "R1 shutdown request blocks start", st_of(0), 0);
    shut_req[0] = 1'b0;
    run_to_good(0, 1, "R1 start after request clears");

    // R8 driver-ready loss in run, then full restart
    drv_ready = 1'b0;
    @(negedge clk);
    chk(!pgood[0] && pwm_tri[0] && st_of(0) == 0, "R8 driver loss", pgood[0], 0);
    repeat (3) @(negedge clk);
    drv_ready = 1'b1;
    run_to_good(0, 1, "R8 full restart");
    supply_ok = 1'b0;
    @(negedge clk);
    chk(!pgood[0] && pwm_tri[0], "R8 supply loss", pgood[0], 0);
    supply_ok = 1'b1;
    run_to_good(0, 1, "R8 restart after supply");

    // R9 shutdown request in run
    shut_req[0] = 1'b1;
    @(negedge clk);
    chk(st_of(0) == 6 && !pgood[0] && pwm_tri[0], "R9 enter shutdown", st_of(0), 6);
    repeat (5) @(negedge clk);
    chk(st_of(0) == 6, "R9 held in shutdown", st_of(0), 6);
    shut_req[0] = 1'b0;
    @(negedge clk);
    chk(st_of(0) == 0, "R9 back to idle", st_of(0), 0);
    run_to_good(0, 1, "R9 full restart");
    drop_en(0);

    // R4 code change during delay ignored
    dly_code[2:0] = 3'd7;
    en[0] = 1'b1;
    repeat (RT + 5) @(negedge clk);
    chk(st_of(0) == 2, "R4 in delay", st_of(0), 2);
    dly_code[2:0] = 3'd0;
    wait_ss(0, n);
    chk(n + RT + 5 == RT + 20 * UT + 1, "R4 code change ignored", n + RT + 5, RT + 20 * UT + 1);
    drop_en(0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule